// File: doc/BRIEF.md
# Encoded SPI Serial-Clock Prescaler

This block derives the serial clock of an SPI engine from its parent clock. A 16-bit select code sets the divide ratio, and the ratio is always a power of two from 1 to 1024. The code has two fields. The low byte is an exponent that picks divide-by-2 through divide-by-32. A high byte of 0x1f adds a fixed pre-division by 32. One reserved code, 0x0007, passes the parent clock straight through.

The block has two independent channels, one for transmit and one for receive. Each channel has its own code input, its own divided clock and its own edge strobe. Software normally writes the same code to both. A shared enable starts and stops both channels, and a shared idle-level input sets the resting level of the serial clock.

The select code and the idle level are captured only while the enable is low. Changing them in the middle of a transfer therefore cannot distort a running period. For every divided ratio, a one-cycle strobe is high in exactly the cycle in which the serial clock has just changed. The shift engine can use this strobe to launch and sample data.

Top module: `sckdiv_top`

## Requirements
- R1: While reset is asserted, both serial clocks and both edge strobes are low.
- R2: After the enable has been low for two edges, each serial clock equals the idle level sampled at the previous edge, and each strobe is low.
- R3: A code with high byte 0x00 and low byte L in 0..4 divides by D = 2^(L+1). Count the first edge that samples the enable high as edge 1. The clock then toggles after every edge n where n is a multiple of D/2, so after edge n it equals idle XOR ((n / (D/2)) mod 2).
- R4: A code with high byte 0x1f and low byte L in 0..4 divides by 32 * 2^(L+1), which gives ratios 64 to 1024. Its timing follows the rule of R3.
- R5: Code 0x0007 gives divide-by-1. After enable edge 2, the clock equals the parent clock XOR the idle level. It sits at the idle level whenever the parent clock is low, and its strobe is high after every enabled edge.
- R6: Every code not listed in R3 to R5 (for example 0x0005, 0x1f05, 0x0100, 0x0107, 0xffff) divides by 1024.
- R7: Changes to a code or to the idle level while the enable is high have no effect on the running clock until the enable has been low for an edge.
- R8: In the divided modes, the strobe is high exactly in the cycles in which the serial clock has just changed level. The clock is stable in every other enabled cycle.
- R9: The transmit and receive channels run from their own codes without affecting each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_en | input | 1 | Run enable for both channels; the setting is captured while it is low |
| idle_lvl | input | 1 | Resting level of the serial clocks |
| tx_code | input | 16 | Transmit clock-select code |
| rx_code | input | 16 | Receive clock-select code |
| tx_sck | output | 1 | Transmit serial clock |
| tx_tgl | output | 1 | Transmit edge strobe |
| rx_sck | output | 1 | Receive serial clock |
| rx_tgl | output | 1 | Receive edge strobe |

## Verification
The assertions take two things for granted. First, the enable and the idle level are driven synchronously to the parent clock. Second, the enable is low for at least one edge before a transfer, so that the captured setting is settled. The stimulus changes every input just after a rising edge, and it holds the enable low for two edges before each run.

The divide-by-1 path contains the parent clock itself, so its level is checked in both clock phases and not only at the edge. The stimulus sweeps every valid code and several reserved ones on both channels at the same time, with the idle level both low and high. In each run it deliberately disturbs the codes and the idle level mid-transfer to show that they are ignored.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;

  // Width of the stored divide exponent (log2 of the divisor).
  localparam int EXP_W = 4;

  typedef struct packed {
    logic             bypass; // parent clock passed through
    logic [EXP_W-1:0] expo;   // divisor = 2**expo when not bypassed
    logic             idle;   // resting level of the serial clock
  } sck_cfg_t;

endpackage

// File: rtl/sckdiv_decode.sv
module sckdiv_decode
  import sckdiv_pkg::*;
#(
  parameter int              CODE_W    = 16,
  parameter int              MAX_EXP   = 10,
  parameter int              PRE_EXP   = 5,
  parameter int              LOW_MAX   = 4,
  parameter logic [CODE_W/2-1:0] PRE_FIELD = 8'h1f,
  parameter logic [CODE_W-1:0]   BYP_CODE  = 16'h0007
) (
  input  logic [CODE_W-1:0] code,
  output logic              bypass,
  output logic [EXP_W-1:0]  expo
);

  localparam int HALF_W = CODE_W / 2;

  logic [HALF_W-1:0] hi_f;
  logic [HALF_W-1:0] lo_f;
  logic              lo_ok;
  logic              hi_plain;
  logic              hi_pre;

  assign hi_f     = code[CODE_W-1:HALF_W];
  assign lo_f     = code[HALF_W-1:0];
  assign lo_ok    = (lo_f <= HALF_W'(LOW_MAX));
  assign hi_plain = (hi_f == '0);
  assign hi_pre   = (hi_f == PRE_FIELD);

  always_comb begin
    bypass = 1'b0;
    expo   = EXP_W'(MAX_EXP);
    if (code == BYP_CODE) begin
      bypass = 1'b1;
      expo   = '0;
    end else if (lo_ok && (hi_plain || hi_pre)) begin
      expo = EXP_W'(lo_f) + EXP_W'(1) + (hi_pre ? EXP_W'(PRE_EXP) : '0);
    end
  end

endmodule

// File: rtl/sckdiv_cfg.sv
module sckdiv_cfg
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             bypass_in,
  input  logic [EXP_W-1:0] expo_in,
  input  logic             idle_in,
  output sck_cfg_t         cfg
);

  sck_cfg_t cfg_d;
  sck_cfg_t cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.bypass = bypass_in;
      cfg_d.expo   = expo_in;
      cfg_d.idle   = idle_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.bypass <= 1'b0;
      cfg_q.expo   <= '1;
      cfg_q.idle   <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/sckdiv_engine.sv
module sckdiv_engine
  import sckdiv_pkg::*;
#(
  parameter int MAX_EXP = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     idle_in,
  input  sck_cfg_t cfg,
  output logic     sck_o,
  output logic     tgl_o
);

  localparam int CNT_W = MAX_EXP - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tgl_q, tgl_d;
  logic             run_q, run_d;
  logic             gate_q, gate_d;
  logic [CNT_W:0]   half_w;
  logic [CNT_W-1:0] lim;

  // Half-period length from the stored exponent.
  assign half_w = (CNT_W+1)'(1) << (cfg.expo - EXP_W'(1));
  assign lim    = CNT_W'(half_w - (CNT_W+1)'(1));

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    tgl_d = 1'b0;
    run_d = run;
    if (!run) begin
      cnt_d = '0;
      sck_d = idle_in;
    end else if (cfg.bypass) begin
      cnt_d = '0;
      tgl_d = 1'b1;
    end else if (cnt_q == lim) begin
      cnt_d = '0;
      sck_d = ~sck_q;
      tgl_d = 1'b1;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
      tgl_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
      tgl_q <= tgl_d;
      run_q <= run_d;
    end
  end

  // Pass-through gate changes only while the parent clock is low.
  assign gate_d = run_q & cfg.bypass;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign sck_o = cfg.bypass ? (cfg.idle ^ (clk & gate_q)) : sck_q;
  assign tgl_o = tgl_q;

endmodule

// File: rtl/sckdiv_top.sv
module sckdiv_top
  import sckdiv_pkg::*;
#(
  parameter int                  CODE_W    = 16,
  parameter int                  MAX_EXP   = 10,
  parameter int                  PRE_EXP   = 5,
  parameter int                  LOW_MAX   = 4,
  parameter logic [CODE_W/2-1:0] PRE_FIELD = 8'h1f,
  parameter logic [CODE_W-1:0]   BYP_CODE  = 16'h0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_en,
  input  logic              idle_lvl,
  input  logic [CODE_W-1:0] tx_code,
  input  logic [CODE_W-1:0] rx_code,
  output logic              tx_sck,
  output logic              tx_tgl,
  output logic              rx_sck,
  output logic              rx_tgl
);

  localparam int NCH = 2;

  logic [CODE_W-1:0] code_arr [NCH];
  logic [NCH-1:0]    sck_vec;
  logic [NCH-1:0]    tgl_vec;
  logic [NCH-1:0]    ch_byp;

  assign code_arr[0] = tx_code;
  assign code_arr[1] = rx_code;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             dec_byp;
    logic [EXP_W-1:0] dec_exp;
    sck_cfg_t         cfg;

    sckdiv_decode #(
      .CODE_W(CODE_W), .MAX_EXP(MAX_EXP), .PRE_EXP(PRE_EXP),
      .LOW_MAX(LOW_MAX), .PRE_FIELD(PRE_FIELD), .BYP_CODE(BYP_CODE)
    ) u_dec (
      .code   (code_arr[g]),
      .bypass (dec_byp),
      .expo   (dec_exp)
    );

    sckdiv_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (!sck_en),
      .bypass_in (dec_byp),
      .expo_in   (dec_exp),
      .idle_in   (idle_lvl),
      .cfg       (cfg)
    );

    sckdiv_engine #(.MAX_EXP(MAX_EXP)) u_eng (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (sck_en),
      .idle_in (idle_lvl),
      .cfg     (cfg),
      .sck_o   (sck_vec[g]),
      .tgl_o   (tgl_vec[g])
    );

    assign ch_byp[g] = cfg.bypass;
  end

  assign tx_sck = sck_vec[0];
  assign tx_tgl = tgl_vec[0];
  assign rx_sck = sck_vec[1];
  assign rx_tgl = tgl_vec[1];

endmodule

// File: rtl/sckdiv_chk.sv
module sckdiv_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sck_en,
  input logic [NCH-1:0] sck_v,
  input logic [NCH-1:0] tgl_v,
  input logic [NCH-1:0] byp_v
);

  for (genvar g = 0; g < NCH; g++) begin : g_p
    // R2: no strobe once disabled
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_en |=> !tgl_v[g]);

    // R8: divided clock holds level without a strobe
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_v[g] && $past(sck_en) && !tgl_v[g]) |-> $stable(sck_v[g]));

    // R8: every strobe marks a level change
    p_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!byp_v[g] && tgl_v[g]) |-> (sck_v[g] != $past(sck_v[g])));

    // R5: pass-through mode strobes every enabled cycle
    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_v[g] && $past(sck_en)) |-> tgl_v[g]);
  end

endmodule

bind sckdiv_top sckdiv_chk #(.NCH(2)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .sck_en (sck_en),
  .sck_v  (sck_vec),
  .tgl_v  (tgl_vec),
  .byp_v  (ch_byp)
);

// File: tb/sim_sckdiv_top.sv
`timescale 1ns/1ps
module sim_sckdiv_top;

  logic        clk;
  logic        rst_n;
  logic        sck_en;
  logic        idle_lvl;
  logic [15:0] tx_code;
  logic [15:0] rx_code;
  logic        tx_sck, tx_tgl, rx_sck, rx_tgl;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sckdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .sck_en(sck_en), .idle_lvl(idle_lvl),
    .tx_code(tx_code), .rx_code(rx_code),
    .tx_sck(tx_sck), .tx_tgl(tx_tgl), .rx_sck(rx_sck), .rx_tgl(rx_tgl)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, expv, $time);
    end
  endtask

  // Divisor expected from the code rules of R3..R6.
  function automatic int exp_div(input logic [15:0] c);
    if (c == 16'h0007) return 1;
    if (c[15:8] == 8'h00 && c[7:0] <= 8'd4) return 2 << c[7:0];
    if (c[15:8] == 8'h1f && c[7:0] <= 8'd4) return 64 << c[7:0];
    return 1024;
  endfunction

  function automatic string cls(input logic [15:0] c);
    if (c == 16'h0007) return "R5";
    if (c[15:8] == 8'h00 && c[7:0] <= 8'd4) return "R3";
    if (c[15:8] == 8'h1f && c[7:0] <= 8'd4) return "R4";
    return "R6";
  endfunction

  function automatic logic [15:0] code_at(input int i);
    if (i < 5)   return 16'(i);
    if (i < 10)  return 16'h1f00 + 16'(i - 5);
    case (i)
      10:      return 16'h0007;
      11:      return 16'h0005;
      12:      return 16'h1f05;
      13:      return 16'h0100;
      14:      return 16'hffff;
      default: return 16'h0107;
    endcase
  endfunction

  task automatic chan(input string tag, input logic s, input logic t,
                      input int d, input logic idl, input int n);
    if (d == 1) begin
      chk({tag, "/R5 strobe"}, t, 1'b1);
      chk({tag, "/R5 sck high phase"}, s, (n >= 2) ? ~idl : idl);
    end else begin
      int h;
      h = d / 2;
      chk({tag, "/R8 strobe"}, t, ((n % h) == 0));
      chk({tag, " sck"}, s, idl ^ logic'((n / h) % 2));
    end
  endtask

  task automatic run_pair(input logic [15:0] ca, input logic [15:0] cb,
                          input logic idl);
    int da, db, nmax;
    string ta, tb;
    sck_en   = 1'b0;
    tx_code  = ca;
    rx_code  = cb;
    idle_lvl = idl;
    step();
    step();
    chk("R2 tx idle", tx_sck, idl);
    chk("R2 rx idle", rx_sck, idl);
    chk("R2 tx strobe", tx_tgl, 1'b0);
    chk("R2 rx strobe", rx_tgl, 1'b0);
    da   = exp_div(ca);
    db   = exp_div(cb);
    nmax = 2 * ((da > db) ? da : db);
    if (nmax < 4) nmax = 4;
    sck_en = 1'b1;
    for (int n = 1; n <= nmax; n++) begin
      step();
      ta = (n > 2) ? {cls(ca), "/R7 tx"} : {cls(ca), " tx"};
      tb = (n > 2) ? {cls(cb), "/R7/R9 rx"} : {cls(cb), "/R9 rx"};
      chan(ta, tx_sck, tx_tgl, da, idl, n);
      chan(tb, rx_sck, rx_tgl, db, idl, n);
      if (da == 1 || db == 1) begin
        #2;
        if (da == 1) chk("R5 tx low phase", tx_sck, idl);
        if (db == 1) chk("R5/R9 rx low phase", rx_sck, idl);
      end
      if (n == 2) begin
        tx_code  = ~ca;
        rx_code  = ~cb;
        idle_lvl = ~idl;
      end
    end
    sck_en = 1'b0;
  endtask

  initial begin
    rst_n    = 1'b0;
    sck_en   = 1'b0;
    idle_lvl = 1'b0;
    tx_code  = 16'h0000;
    rx_code  = 16'h0000;
    step();
    step();
    chk("R1 tx sck", tx_sck, 1'b0);
    chk("R1 tx strobe", tx_tgl, 1'b0);
    chk("R1 rx sck", rx_sck, 1'b0);
    chk("R1 rx strobe", rx_tgl, 1'b0);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) begin
        run_pair(code_at(i), code_at(15 - i), logic'((i + p) % 2));
      end
    end
    step();
    step();
    chk("R2 final tx idle", tx_sck, idle_lvl);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule